// File: doc/BRIEF.md
# Bufferless Deflection Switch for a 4x4 Wrapped Torus

The block is one router node of a two-dimensional folded torus. It has four network links (north, east, south, west) and one local link to a processing element. Every flit on every input is routed by itself, with no packet state. The switch keeps one register per input and no queues. It never stalls an upstream neighbour.

A flit captured in one cycle leaves on some output in the next cycle. It takes its productive direction toward its destination when that port is free. When another flit has already claimed that port, the switch sends it out on a free network port instead. Because of this, flits of one packet can take different paths and can arrive out of order. A flit addressed to this node leaves on the local ejection port. The local processing element can inject a flit only when the incoming network traffic leaves room for it. If there is no room, the injection is held off and the source must keep its flit.

Top module: `deflect_torus_switch`

## Requirements
- R1: Each valid flit captured at a rising edge appears on exactly one output after that edge. No flit is dropped or duplicated, and no output is valid without a captured flit.
- R2: The flit layout, for the default 4x4 size with a 64-bit payload, is as follows. Bit 68 is valid, bits 67:66 are destination X, bits 65:64 are destination Y, and bits 63:0 are the payload.
- R3: A flit whose destination equals the node's coordinates leaves on `ej_o` when no higher-priority flit has taken the ejection port.
- R4: X is resolved first. Let dx = (dst_x - node_x) mod 4. A dx of 1 or 2 routes east, where the tie at 2 takes the positive direction. A dx of 3 routes west.
- R5: Once dx is 0, let dy = (dst_y - node_y) mod 4. A dy of 1 or 2 routes north, where the tie at 2 is positive. A dy of 3 routes south.
- R6: When flits want the same output, the lower input index wins. The input indices are: north 0, east 1, south 2, west 3, local injection 4.
- R7: A flit that loses takes the lowest-indexed free network output. The output indices are: north 0, east 1, south 2, west 3.
- R8: An ejecting flit that finds the ejection port taken is deflected to the lowest-indexed free network output. A flit is never sent to the ejection port unless it is addressed to this node.
- R9: `inj_ready_o` is high exactly when fewer than four network inputs carry a valid flit. While it is low, the injection input is ignored.
- R10: While reset is asserted, every output flit is invalid.
- R11: The payload and destination fields of a flit leave the switch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| net_in_i | input | 4x69 | Incoming flits from the N/E/S/W links (index 0..3) |
| inj_i | input | 69 | Flit offered by the local processing element |
| inj_ready_o | output | 1 | Injection accepted this cycle |
| net_out_o | output | 4x69 | Outgoing flits to the N/E/S/W links (index 0..3) |
| ej_o | output | 69 | Flit ejected to the local processing element |

## Verification
Network flits and injected flits are captured at a rising edge and appear on the outputs after that same edge. The bench therefore expects every routing, deflection and ejection result one cycle after it drives a stimulus. The monitor compares these results a quarter period after the next rising edge. `inj_ready_o` depends combinationally on the network inputs, so the bench checks it in the same cycle, just after it drives them. Checking the outputs in the following cycle shows whether a held-off injection was dropped.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int NUM_NET = 4;
  localparam int NUM_IN  = NUM_NET + 1;
  localparam int PW      = 3;

  localparam logic [PW-1:0] P_NORTH = 3'd0;
  localparam logic [PW-1:0] P_EAST  = 3'd1;
  localparam logic [PW-1:0] P_SOUTH = 3'd2;
  localparam logic [PW-1:0] P_WEST  = 3'd3;
  localparam logic [PW-1:0] P_LOCAL = 3'd4;
endpackage

// File: rtl/dts_route.sv
module dts_route
  import dts_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int CW     = $clog2(DIM),
  parameter int NODE_X = 0,
  parameter int NODE_Y = 0
) (
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  output logic [PW-1:0] pref_o
);
  localparam logic [CW-1:0] HX   = CW'(NODE_X);
  localparam logic [CW-1:0] HY   = CW'(NODE_Y);
  localparam logic [CW-1:0] HALF = CW'(DIM / 2);

  logic [CW-1:0] dx, dy;

  // DIM is a power of two, so the subtraction wraps on the ring
  always_comb begin
    dx = dst_x_i - HX;
    dy = dst_y_i - HY;
    if (dx != '0)      pref_o = (dx <= HALF) ? P_EAST : P_WEST;
    else if (dy != '0) pref_o = (dy <= HALF) ? P_NORTH : P_SOUTH;
    else               pref_o = P_LOCAL;
  end
endmodule

// File: rtl/dts_alloc.sv
module dts_alloc
  import dts_pkg::*;
(
  input  logic [NUM_IN-1:0]         vld_i,
  input  logic [NUM_IN-1:0][PW-1:0] pref_i,
  output logic [NUM_IN-1:0][PW-1:0] sel_o
);
  logic [NUM_IN-1:0] taken;
  logic [NUM_IN-1:0] lose;
  logic              found;

  always_comb begin
    taken = '0;
    lose  = '0;
    found = 1'b0;
    sel_o = '0;
    // pass 1: productive port in fixed input priority
    for (int i = 0; i < NUM_IN; i++) begin
      if (vld_i[i]) begin
        if (!taken[pref_i[i]]) begin
          sel_o[i]           = pref_i[i];
          taken[pref_i[i]]   = 1'b1;
        end else begin
          lose[i] = 1'b1;
        end
      end
    end
    // pass 2: deflect losers to lowest free network port
    for (int i = 0; i < NUM_IN; i++) begin
      found = 1'b0;
      if (lose[i]) begin
        for (int p = 0; p < NUM_NET; p++) begin
          if (!found && !taken[p]) begin
            sel_o[i] = PW'(p);
            taken[p] = 1'b1;
            found    = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/deflect_torus_switch.sv
module deflect_torus_switch
  import dts_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int DATA_W = 64,
  parameter int NODE_X = 0,
  parameter int NODE_Y = 0,
  // derived, keep at default
  parameter int CW     = $clog2(DIM),
  parameter int FW     = 1 + 2 * CW + DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_NET-1:0][FW-1:0] net_in_i,
  input  logic [FW-1:0]              inj_i,
  output logic                       inj_ready_o,
  output logic [NUM_NET-1:0][FW-1:0] net_out_o,
  output logic [FW-1:0]              ej_o
);
  localparam int VB  = FW - 1;
  localparam int XH  = FW - 2;
  localparam int YH  = FW - 2 - CW;
  localparam int CNW = $clog2(NUM_NET + 1);

  logic [CNW-1:0]                net_cnt;
  logic                          inj_take;
  logic [NUM_IN-1:0][FW-1:0]     stage_d, stage_q;
  logic [NUM_IN-1:0]             vld;
  logic [NUM_IN-1:0][PW-1:0]     pref, sel;

  always_comb begin
    net_cnt = '0;
    for (int i = 0; i < NUM_NET; i++) net_cnt = net_cnt + CNW'(net_in_i[i][VB]);
  end

  // a slot is free only if fewer network flits arrive than network outputs
  assign inj_ready_o = (net_cnt < CNW'(NUM_NET));
  assign inj_take    = inj_i[VB] & inj_ready_o;

  always_comb begin
    for (int i = 0; i < NUM_NET; i++)
      stage_d[i] = net_in_i[i][VB] ? net_in_i[i] : '0;
    stage_d[NUM_IN-1] = inj_take ? inj_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_route
    assign vld[g] = stage_q[g][VB];
    dts_route #(
      .DIM   (DIM),
      .CW    (CW),
      .NODE_X(NODE_X),
      .NODE_Y(NODE_Y)
    ) u_route (
      .dst_x_i(stage_q[g][XH -: CW]),
      .dst_y_i(stage_q[g][YH -: CW]),
      .pref_o (pref[g])
    );
  end

  dts_alloc u_alloc (
    .vld_i (vld),
    .pref_i(pref),
    .sel_o (sel)
  );

  always_comb begin
    net_out_o = '0;
    ej_o      = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (vld[i]) begin
        if (sel[i] == P_LOCAL) ej_o = stage_q[i];
        else                   net_out_o[sel[i][1:0]] = stage_q[i];
      end
    end
  end
endmodule

// File: rtl/deflect_torus_switch_chk.sv
module deflect_torus_switch_chk
  import dts_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int DATA_W = 64,
  parameter int NODE_X = 0,
  parameter int NODE_Y = 0,
  parameter int CW     = $clog2(DIM),
  parameter int FW     = 1 + 2 * CW + DATA_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_NET-1:0][FW-1:0] net_in_i,
  input logic [FW-1:0]              inj_i,
  input logic                       inj_ready_o,
  input logic [NUM_NET-1:0][FW-1:0] net_out_o,
  input logic [FW-1:0]              ej_o
);
  localparam int VB = FW - 1;
  localparam int XH = FW - 2;
  localparam int YH = FW - 2 - CW;

  logic       past_ok;
  logic [3:0] in_cnt, out_cnt;
  logic [NUM_NET-1:0] in_v, out_v, out_home;

  always_comb begin
    for (int i = 0; i < NUM_NET; i++) begin
      in_v[i]     = net_in_i[i][VB];
      out_v[i]    = net_out_o[i][VB];
      out_home[i] = net_out_o[i][VB] && net_out_o[i][XH -: CW] == CW'(NODE_X)
                    && net_out_o[i][YH -: CW] == CW'(NODE_Y);
    end
    in_cnt  = 4'($countones(in_v)) + 4'(inj_i[VB] & inj_ready_o);
    out_cnt = 4'($countones(out_v)) + 4'(ej_o[VB]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_conserve_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> out_cnt == $past(in_cnt));

  assert_eject_home_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ej_o[VB]) |-> (ej_o[XH -: CW] == CW'(NODE_X) && ej_o[YH -: CW] == CW'(NODE_Y)));

  assert_deflect_home_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && out_home != '0) |-> ej_o[VB]);

  assert_inj_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_ready_o |-> in_v == '1);
endmodule

bind deflect_torus_switch deflect_torus_switch_chk #(
  .DIM(DIM), .DATA_W(DATA_W), .NODE_X(NODE_X), .NODE_Y(NODE_Y)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .net_in_i(net_in_i), .inj_i(inj_i),
  .inj_ready_o(inj_ready_o), .net_out_o(net_out_o), .ej_o(ej_o)
);

// File: tb/deflect_torus_switch_tb.sv
module deflect_torus_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 69;

  typedef logic [FW-1:0]        flit_t;
  typedef logic [3:0][FW-1:0]   quad_t;
  typedef struct {
    quad_t net;
    flit_t ej;
    string tag;
  } exp_t;

  logic  clk = 1'b0;
  logic  rst_ni = 1'b0;
  quad_t net_in = '0;
  flit_t inj = '0;
  logic  inj_ready;
  quad_t net_out;
  flit_t ej;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  deflect_torus_switch #(.NODE_X(1), .NODE_Y(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .net_in_i(net_in), .inj_i(inj),
    .inj_ready_o(inj_ready), .net_out_o(net_out), .ej_o(ej)
  );

  // R2 layout: {valid, x[1:0], y[1:0], data[63:0]}
  function automatic flit_t mk(input int x, input int y, input logic [63:0] d);
    return {1'b1, 2'(x), 2'(y), d};
  endfunction

  task automatic step(input quad_t ni, input flit_t fi, input logic rdy,
                      input quad_t en, input flit_t ee, input string tag);
    exp_t e;
    @(negedge clk);
    net_in = ni;
    inj    = fi;
    #1;
    checks++;
    if (inj_ready !== rdy) begin
      errors++;
      $display("FAIL %s R9 inj_ready actual=%b expected=%b", tag, inj_ready, rdy);
    end
    e.net = en; e.ej = ee; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: results are due one edge after the stimulus
  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (net_out !== e.net || ej !== e.ej) begin
        errors++;
        $display("FAIL %s net actual=%h expected=%h ej actual=%h expected=%h",
                 e.tag, net_out, e.net, ej, e.ej);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    quad_t ni, en;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (net_out !== '0 || ej !== '0) begin   // R10
      errors++;
      $display("FAIL R10 reset outputs actual=%h/%h expected=0", net_out, ej);
    end
    rst_ni = 1'b1;

    // R4 R11: dx=1 east
    ni = '0; en = '0;
    ni[0] = mk(2, 1, 64'hA0A0_0000_0000_0001); en[1] = ni[0];
    step(ni, '0, 1'b1, en, '0, "R4_east");

    // R4: tie dx=2 east, dx=3 west
    ni = '0; en = '0;
    ni[1] = mk(3, 1, 64'h1111); en[1] = ni[1];
    ni[2] = mk(0, 1, 64'h2222); en[3] = ni[2];
    step(ni, '0, 1'b1, en, '0, "R4_tie_west");

    // R5: dy=1 north, dy=3 south
    ni = '0; en = '0;
    ni[3] = mk(1, 2, 64'h3333); en[0] = ni[3];
    ni[0] = mk(1, 0, 64'h4444); en[2] = ni[0];
    step(ni, '0, 1'b1, en, '0, "R5_north_south");

    // R5 tie north; R3 injected flit ejected
    ni = '0; en = '0;
    ni[2] = mk(1, 3, 64'h5555); en[0] = ni[2];
    step(ni, mk(1, 1, 64'hCAFE), 1'b1, en, mk(1, 1, 64'hCAFE), "R5_tie_R3_eject");

    // R6 R7: two flits want east, lower input wins, loser to north
    ni = '0; en = '0;
    ni[0] = mk(2, 1, 64'h6666); en[1] = ni[0];
    ni[2] = mk(2, 0, 64'h7777); en[0] = ni[2];
    step(ni, '0, 1'b1, en, '0, "R6_R7_conflict");

    // R8: two flits for this node
    ni = '0; en = '0;
    ni[1] = mk(1, 1, 64'h8888);
    ni[3] = mk(1, 1, 64'h9999); en[0] = ni[3];
    step(ni, '0, 1'b1, en, mk(1, 1, 64'h8888), "R8_second_eject");

    // R9: four network flits, injection ignored
    ni = '0; en = '0;
    ni[0] = mk(2, 1, 64'h10); en[1] = ni[0];
    ni[1] = mk(0, 1, 64'h11); en[3] = ni[1];
    ni[2] = mk(1, 2, 64'h12); en[0] = ni[2];
    ni[3] = mk(1, 0, 64'h13); en[2] = ni[3];
    step(ni, mk(1, 1, 64'hDEAD), 1'b0, en, '0, "R9_held_off");

    // R6 R7: all four want east
    ni = '0; en = '0;
    ni[0] = mk(2, 1, 64'h20); en[1] = ni[0];
    ni[1] = mk(2, 1, 64'h21); en[0] = ni[1];
    ni[2] = mk(2, 1, 64'h22); en[2] = ni[2];
    ni[3] = mk(2, 1, 64'h23); en[3] = ni[3];
    step(ni, '0, 1'b0, en, '0, "R6_R7_all_east");

    // R8: four flits for this node
    ni = '0; en = '0;
    ni[0] = mk(1, 1, 64'h30);
    ni[1] = mk(1, 1, 64'h31); en[0] = ni[1];
    ni[2] = mk(1, 1, 64'h32); en[1] = ni[2];
    ni[3] = mk(1, 1, 64'h33); en[2] = ni[3];
    step(ni, '0, 1'b0, en, mk(1, 1, 64'h30), "R8_all_home");

    // R9 R6: three network plus injection all east
    ni = '0; en = '0;
    ni[0] = mk(2, 1, 64'h40); en[1] = ni[0];
    ni[1] = mk(2, 1, 64'h41); en[0] = ni[1];
    ni[2] = mk(2, 1, 64'h42); en[2] = ni[2];
    en[3] = mk(2, 1, 64'h43);
    step(ni, mk(2, 1, 64'h43), 1'b1, en, '0, "R9_R6_inject_deflect");

    // R1: idle gives no outputs
    step('0, '0, 1'b1, '0, '0, "R1_idle");
    step('0, '0, 1'b1, '0, '0, "R1_idle2");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule